// File: doc/BRIEF.md
# Sequential Integer Square Root Engine

This block finds the integer square root of an unsigned radicand of 2N bits, together with the residue that is left over. A single trial-subtract stage is reused on every clock, so one root bit is settled per cycle. A full computation costs N cycles and needs only one N+2-bit subtractor. The alternative, a chain of N stages, would need N subtractors.

A caller presents a radicand and raises `start_i` for one cycle while the engine is idle. The engine copies the radicand into an internal shift register and clears its partial root and partial remainder. It then raises `busy_o`. On each busy cycle it takes the next two radicand bits, working from the most significant pair down to pair 0. It places them below the partial remainder shifted left by two, and compares the result with the partial root shifted left by two with binary 01 appended. If the trial value is not smaller, the difference becomes the new remainder and a 1 is shifted into the root. Otherwise the trial value is kept and a 0 is shifted in.

When the last pair has been processed, `done_o` pulses for one cycle. The root and remainder outputs then hold until the next accepted start. The reset is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `isqrt_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o`, `done_o`, `root_o` and `rem_o` are all 0.
- R2: A `start_i` that is high at a rising edge while `busy_o` is low is accepted. `busy_o` is then high for exactly N consecutive cycles, beginning in the cycle after that edge.
- R3: `done_o` is high for exactly one cycle, N cycles after the accepting edge. That is the same cycle in which `busy_o` first reads low again.
- R4: When `done_o` is high, `root_o` equals floor(sqrt(radicand)) and `root_o*root_o + rem_o` equals the radicand that was accepted. This holds for 0, 1, perfect squares, the all-ones value and random values.
- R5: From the `done_o` cycle until the next accepted start, `root_o` and `rem_o` do not change, even if `radicand_i` changes.
- R6: A `start_i` that is high while `busy_o` is high is ignored. The running computation keeps its radicand and its timing.
- R7: When `done_o` is high, `rem_o` is at most 2*`root_o`. For the all-ones radicand, `rem_o` is 2*(2^N-1), which fits in the N+2-bit remainder.
- R8: The radicand is sampled only at the accepting edge. Changes on `radicand_i` while `busy_o` is high have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| radicand_i | input | 2N | Unsigned radicand, sampled on an accepted start |
| busy_o | output | 1 | High while the bit pairs are being processed |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| root_o | output | N | Integer square root |
| rem_o | output | N+2 | Remainder, radicand minus root squared |

## Verification
A wrong iteration count or a wrong sequencing state shows directly in the length of the `busy_o` window and in the position of `done_o`. Either one is visible N cycles after the start. An error in the compare-subtract step, or in the order in which bit pairs are taken, shows only at `done_o`. It appears as a root that is not floor(sqrt) or as a residue outside 0..2*root. Both are checked against the recovered identity root*root+rem. A start or radicand change that leaks into a running computation also shows at the next `done_o`, as a result for the wrong operand.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } isqrt_state_e;
endpackage

// File: rtl/isqrt_rst_sync.sv
module isqrt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/isqrt_step.sv
// One restoring trial-subtract stage, purely combinational.
module isqrt_step #(
  parameter int N = 8
) (
  input  logic [N-1:0]   rem_i,   // low N bits of the partial remainder
  input  logic [N-1:0]   root_i,
  input  logic [1:0]     pair_i,
  output logic [N+1:0]   rem_nx_o,
  output logic [N-1:0]   root_nx_o
);
  logic [N+1:0] trial;
  logic [N+1:0] cmpv;
  logic         fits;

  always_comb begin
    trial     = {rem_i, pair_i};
    cmpv      = {root_i, 2'b01};
    fits      = (trial >= cmpv);
    rem_nx_o  = fits ? (trial - cmpv) : trial;
    root_nx_o = {root_i[N-2:0], fits};
  end
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  isqrt_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = CW'(N - 1);
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [2*N-1:0] radicand_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N-1:0]   root_o,
  output logic [N+1:0]   rem_o
);
  localparam int RW = 2 * N;
  localparam int MW = N + 2;

  logic rst_n_int;
  logic load, step;

  logic [RW-1:0] sreg_q, sreg_d;
  logic [MW-1:0] rem_q, rem_d, rem_step;
  logic [N-1:0]  root_q, root_d, root_step;

  isqrt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  isqrt_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  isqrt_step #(.N(N)) u_step (
    .rem_i     (rem_q[N-1:0]),
    .root_i    (root_q),
    .pair_i    (sreg_q[RW-1:RW-2]),
    .rem_nx_o  (rem_step),
    .root_nx_o (root_step)
  );

  always_comb begin
    sreg_d = sreg_q;
    rem_d  = rem_q;
    root_d = root_q;
    if (load) begin
      sreg_d = radicand_i;
      rem_d  = '0;
      root_d = '0;
    end else if (step) begin
      sreg_d = {sreg_q[RW-3:0], 2'b00};
      rem_d  = rem_step;
      root_d = root_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sreg_q <= '0;
      rem_q  <= '0;
      root_q <= '0;
    end else if (load || step) begin
      sreg_q <= sreg_d;
      rem_q  <= rem_d;
      root_q <= root_d;
    end
  end

  assign root_o = root_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/isqrt_seq_chk.sv
module isqrt_seq_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [2*N-1:0] radicand_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N-1:0]   root_o,
  input logic [N+1:0]   rem_o
);
  localparam int LW = $clog2(N + 2) + 1;
  localparam int PW = 2 * N + 2;

  logic [LW-1:0]  run_len;
  logic [2*N-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      cap     <= '0;
    end else begin
      run_len <= busy_o ? run_len + 1'b1 : '0;
      if (start_i && !busy_o) cap <= radicand_i;
    end
  end

  // R2: an accepted start makes the engine busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R2: busy window never exceeds N cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= LW'(N));

  // R3: done only after exactly N busy cycles
  p_done_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == LW'(N)) && !busy_o);

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: identity against the captured radicand
  p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (PW'(root_o) * PW'(root_o) + PW'(rem_o)) == PW'(cap));

  // R5: idle outputs hold without a start
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(root_o) && $stable(rem_o)));

  // R7: residue bound
  p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ({1'b0, rem_o} <= {2'b00, root_o, 1'b0}));
endmodule

bind isqrt_seq isqrt_seq_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .radicand_i (radicand_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .root_o     (root_o),
  .rem_o      (rem_o)
);

// File: tb/isqrt_seq_tb_top.sv
module isqrt_seq_tb_top;
  localparam int N = 8;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [2*N-1:0] radicand_i;
  logic           busy_o;
  logic           done_o;
  logic [N-1:0]   root_o;
  logic [N+1:0]   rem_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  isqrt_seq #(.N(N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .radicand_i (radicand_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .root_o     (root_o),
    .rem_o      (rem_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_root(input int x);
    int r = 0;
    for (int c = 0; c < (1 << N); c++) if (c * c <= x) r = c;
    return r;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Starts at a negedge, returns at the negedge after done_o; checks R2/R3/R4/R7.
  // Optionally pulses a stray start or changes the radicand mid-run (R6, R8).
  task automatic run_one(input int x, input bit stray_start, input bit wiggle);
    int er = ref_root(x);
    int rem_e = x - er * er;
    start_i = 1'b1;
    radicand_i = (2*N)'(x);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
    for (int k = 1; k < N; k++) begin
      if (k == 2 && stray_start) begin
        start_i = 1'b1;
        radicand_i = ~(2*N)'(x);
      end
      if (k == 3) start_i = 1'b0;
      if (wiggle) radicand_i = (2*N)'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(busy_o == 1'b1 && done_o == 1'b0, "R2 still busy at cycle N-1",
          longint'({busy_o, done_o}), 2);
    @(posedge clk);
    @(negedge clk);
    check(done_o == 1'b1 && busy_o == 1'b0, "R3 done at cycle N",
          longint'({busy_o, done_o}), 1);
    check(int'(root_o) == er, stray_start ? "R6 root" : (wiggle ? "R8 root" : "R4 root"),
          longint'(root_o), longint'(er));
    check(int'(rem_o) == rem_e, "R4 remainder", longint'(rem_o), longint'(rem_e));
    check(int'(rem_o) <= 2 * int'(root_o), "R7 remainder bound",
          longint'(rem_o), longint'(2 * int'(root_o)));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    radicand_i = '0;
    #1;
    check({busy_o, done_o} == 2'b00 && root_o == '0 && rem_o == '0, "R1 in reset",
          longint'({busy_o, done_o, root_o, rem_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o} == 2'b00 && root_o == '0 && rem_o == '0, "R1 after release",
          longint'({busy_o, done_o, root_o, rem_o}), 0);
  endtask

  task automatic test_edges();
    run_one(0, 0, 0);
    run_one(1, 0, 0);
    run_one(4, 0, 0);
    run_one(144, 0, 0);
    run_one(255 * 255, 0, 0);
    run_one((1 << (2*N)) - 1, 0, 0);
    check(int'(rem_o) == 2 * ((1 << N) - 1), "R7 all-ones remainder",
          longint'(rem_o), longint'(2 * ((1 << N) - 1)));
  endtask

  task automatic test_done_pulse();
    run_one(200, 0, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R3 done lasts one cycle", longint'(done_o), 0);
  endtask

  task automatic test_hold();
    int er;
    run_one(5000, 0, 0);
    er = ref_root(5000);
    for (int k = 0; k < 5; k++) begin
      radicand_i = (2*N)'($urandom);
      @(negedge clk);
    end
    check(int'(root_o) == er && int'(rem_o) == 5000 - er * er && !busy_o,
          "R5 outputs hold", longint'(root_o), longint'(er));
  endtask

  task automatic test_ignore_start();
    run_one(40000, 1, 0);
    run_one(12345, 0, 1);
  endtask

  task automatic test_back_to_back();
    run_one(999, 0, 0);
    run_one(1000, 0, 0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 30; i++) run_one(int'($urandom_range(0, (1 << (2*N)) - 1)), 0, 0);
  endtask

  task automatic test_reset_midrun();
    start_i = 1'b1;
    radicand_i = 16'd50000;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({busy_o, done_o} == 2'b00 && root_o == '0 && rem_o == '0, "R1 reset mid-run",
          longint'({busy_o, done_o, root_o, rem_o}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_one(81, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    test_reset();
    test_edges();
    test_done_pulse();
    test_hold();
    test_ignore_start();
    test_back_to_back();
    test_random();
    test_reset_midrun();
    finish_run();
  end
endmodule